// File: doc/BRIEF.md
# Cartridge disk controller register file

This block is the processor-facing register set of a controller that serves four cartridge disk drives. Software reaches five 16-bit registers through a word-aligned byte offset. They are a control and status word, a memory bus address, a disk address, a multipurpose register backed by a three-entry queue, and a 6-bit memory address extension. Writes can be full words or single bytes. Reads return data combinationally in the cycle the access is presented. A read of the multipurpose register also advances its queue at the clock edge.

The block does not run commands. A control write whose done bit is zero launches a command. The block then raises a one-cycle start pulse and presents the function code and drive number on dedicated outputs. The execution engine reports the end of the command with a completion strobe and five error flags. The block keeps the interrupt request and the error summary consistent with the enable and done bits.

A mode input states whether the extension register exists. When it is low, the register gives no bus response and ignores writes. The two low extension bits stay visible in the control word in both modes.

Top module: `cart_disk_regs`

## Requirements
- R1: After reset, every register and queue entry is zero except the done bit (bit 7), which is one. The interrupt request and start pulse are low. The control word therefore reads 0x0081 when drive 0 is idle.
- R2: `bus_addr[3:1]` selects the register: 0 control word, 1 bus address, 2 disk address, 3 multipurpose, 4 extension. Indices 5 to 7 give `bus_ack` low. Index 4 gives `bus_ack` low and ignores writes while `mode_ext` is low.
- R3: Control-word bits 9:1 are the only bits software can write. A write with done = 1 leaves error bits 14:10 unchanged, whatever data it carries in bits 15:10.
- R4: Control-word bits 5:4 always read as extension bits 1:0. Writing either register updates the shared bits.
- R5: On read, control-word bit 15 is the OR of bits 14:10. Bit 0 is the inverse of `drive_busy` for the drive selected in bits 9:8.
- R6: A byte write (`bus_byte` high) takes its data from `bus_wdata[7:0]`. An odd address (`bus_addr[0]` = 1) replaces the high byte and an even address replaces the low byte. The other byte keeps its current value. An odd byte write to the extension register is ignored.
- R7: Bus-address bit 0 always reads 0. The extension register holds 6 bits and reads zero above them.
- R8: A multipurpose write loads every queue entry with the (byte-merged) value. A multipurpose read returns entry 0. It then moves entry 1 to entry 0 and entry 2 to entry 1, and entry 2 keeps its value.
- R9: A control write with done = 1 and IE (bit 6) = 0 drops `irq`. A control write with done = 1 and IE = 1 raises `irq` when done was already 1 and IE was 0 before the write.
- R10: A control write with done = 0 clears `irq` and error bits 15:10. It pulses `cmd_start` for exactly the next cycle, with `cmd_func` = bits 3:1 and `cmd_drive` = bits 9:8 of the written value. Function codes: 0 no-op, 1 write check, 2 get status, 3 seek, 4 read header, 5 write, 6 read, 7 read without header check.
- R11: `done_strobe` sets done and ORs `done_err[4:0]` into control bits 14:10. It raises `irq` when IE is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 1: extension register present |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_byte | input | 1 | Byte-sized write |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| bus_ack | output | 1 | Access hit an existing register |
| drive_busy | input | 4 | Per-drive busy flags |
| done_strobe | input | 1 | Command completion |
| done_err | input | 5 | Error flags for control bits 14:10 |
| irq | output | 1 | Interrupt request |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_func | output | 3 | Function of the launched command |
| cmd_drive | output | 2 | Drive of the launched command |

## Verification
The bench targets the shared extension bits from both sides. A design that stores them twice would show stale bits 5:4 or a stale extension value. It checks that the interrupt is raised only on a true 0-to-1 IE change while done is set. A wrong design would interrupt on every IE=1 write, or never. It drives byte writes to both lanes of several registers. Wrong lane handling would corrupt the untouched byte or set bus-address bit 0. It also checks that errors survive a done = 1 write but are cleared by a start. It accesses the extension register in the mode where it is absent, where a leak would acknowledge the access or alter stored bits.

// File: rtl/dkr_pkg.sv
package dkr_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int DRV_W    = 2;
  localparam int NUM_DRV  = 1 << DRV_W;
  localparam int ERR_W    = 5;
  localparam int MX_W     = 2;

  // control word field positions
  localparam int C_RDY    = 0;
  localparam int C_FN_LO  = 1;
  localparam int C_MX_LO  = 4;
  localparam int C_IE     = 6;
  localparam int C_DONE   = 7;
  localparam int C_DRV_LO = 8;
  localparam int C_ERR_LO = 10;
  localparam int C_SUM    = 15;

  // register index = byte offset / 2
  localparam logic [2:0] RI_CSR = 3'd0;
  localparam logic [2:0] RI_BA  = 3'd1;
  localparam logic [2:0] RI_DA  = 3'd2;
  localparam logic [2:0] RI_MP  = 3'd3;
  localparam logic [2:0] RI_EXT = 3'd4;

  typedef enum logic [2:0] {
    FN_NOP    = 3'd0,
    FN_WCHK   = 3'd1,
    FN_STATUS = 3'd2,
    FN_SEEK   = 3'd3,
    FN_RDHDR  = 3'd4,
    FN_WRITE  = 3'd5,
    FN_READ   = 3'd6,
    FN_RDRAW  = 3'd7
  } dk_func_e;

  function automatic logic [WORD_W-1:0] lane_merge(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] wd,
    input logic              is_byte,
    input logic              hi);
    logic [WORD_W-1:0] r;
    if (!is_byte)  r = wd;
    else if (hi)   r = {wd[7:0], cur[7:0]};
    else           r = {cur[WORD_W-1:8], wd[7:0]};
    return r;
  endfunction
endpackage

// File: rtl/dkr_csr_ctl.sv
module dkr_csr_ctl
  import dkr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_func,
  input  logic             wr_ie,
  input  logic             wr_done,
  input  logic [DRV_W-1:0] wr_drv,
  input  logic             done_strobe,
  input  logic [ERR_W-1:0] done_err,
  output logic [2:0]       func_q,
  output logic             ie_q,
  output logic             done_q,
  output logic [DRV_W-1:0] drv_q,
  output logic [ERR_W-1:0] err_q,
  output logic             irq_q,
  output logic             start_q
);
  dk_func_e         fn_q, fn_d;
  logic             ie_d, done_d, irq_d, start_d;
  logic [DRV_W-1:0] drv_d;
  logic [ERR_W-1:0] err_d;

  always_comb begin
    fn_d    = fn_q;
    ie_d    = ie_q;
    done_d  = done_q;
    drv_d   = drv_q;
    err_d   = err_q;
    irq_d   = irq_q;
    start_d = 1'b0;
    if (wr_en) begin
      fn_d   = dk_func_e'(wr_func);
      ie_d   = wr_ie;
      done_d = wr_done;
      drv_d  = wr_drv;
      if (wr_done) begin
        if (!wr_ie)
          irq_d = 1'b0;
        else if (done_q && !ie_q)
          irq_d = 1'b1;
      end else begin
        irq_d   = 1'b0;
        err_d   = '0;
        start_d = 1'b1;
      end
    end
    if (done_strobe) begin
      done_d = 1'b1;
      err_d  = err_d | done_err;
      if (ie_d) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q    <= FN_NOP;
      ie_q    <= 1'b0;
      done_q  <= 1'b1;
      drv_q   <= '0;
      err_q   <= '0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      fn_q    <= fn_d;
      ie_q    <= ie_d;
      done_q  <= done_d;
      drv_q   <= drv_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
      start_q <= start_d;
    end
  end

  assign func_q = fn_q;

  // R9: a pending interrupt always has done and enable set
  p_irq_done_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (done_q && ie_q));
  // R11: completion leaves done set
  p_done_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_strobe |=> done_q);
endmodule

// File: rtl/dkr_addr_regs.sv
module dkr_addr_regs
  import dkr_pkg::*;
#(
  parameter int EXT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ba_we,
  input  logic [WORD_W-1:1] ba_wdata,
  input  logic              da_we,
  input  logic [WORD_W-1:0] da_wdata,
  input  logic              ext_we,
  input  logic              ext_en,
  input  logic [EXT_W-1:0]  ext_wdata,
  input  logic              mx_we,
  input  logic [MX_W-1:0]   mx_wdata,
  output logic [WORD_W-1:0] ba_q,
  output logic [WORD_W-1:0] da_q,
  output logic [EXT_W-1:0]  ext_q
);
  localparam int BA_W = WORD_W - 1;

  logic [BA_W-1:0]   ba_r, ba_d;
  logic [WORD_W-1:0] da_d;
  logic [EXT_W-1:0]  ext_d;

  always_comb begin
    ba_d  = ba_r;
    da_d  = da_q;
    ext_d = ext_q;
    if (ba_we) ba_d = ba_wdata;
    if (da_we) da_d = da_wdata;
    if (ext_we && ext_en)
      ext_d = ext_wdata;
    else if (mx_we)
      ext_d[MX_W-1:0] = mx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_r  <= '0;
      da_q  <= '0;
      ext_q <= '0;
    end else begin
      ba_r  <= ba_d;
      da_q  <= da_d;
      ext_q <= ext_d;
    end
  end

  assign ba_q = {ba_r, 1'b0};

  // R2: absent extension register keeps its contents
  p_ext_absent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && !ext_en && !mx_we) |=> $stable(ext_q));
  // R4: extension write lands in full
  p_ext_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && ext_en) |=> (ext_q == $past(ext_wdata)));
endmodule

// File: rtl/dkr_mp_queue.sv
module dkr_mp_queue #(
  parameter int DEPTH = 3,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         pop,
  output logic [W-1:0] head
);
  logic [W-1:0] q   [DEPTH];
  logic [W-1:0] q_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i < DEPTH - 1) begin : g_mid
      always_comb begin
        q_d[i] = q[i];
        if (load)     q_d[i] = load_data;
        else if (pop) q_d[i] = q[i+1];
      end
    end else begin : g_tail
      always_comb begin
        q_d[i] = q[i];
        if (load) q_d[i] = load_data;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= q_d[i];
    end
  end

  assign head = q[0];

  // R8: write broadcasts to the last entry as well
  p_load_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q[DEPTH-1] == $past(load_data)));
  if (DEPTH > 1) begin : g_chk
    // R8: read moves the queue forward by one
    p_pop_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !load) |=> (q[0] == $past(q[1])));
  end
endmodule

// File: rtl/cart_disk_regs.sv
module cart_disk_regs
  import dkr_pkg::*;
#(
  parameter int EXT_W     = 6,
  parameter int MPQ_DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_ext,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_byte,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               bus_ack,
  input  logic [NUM_DRV-1:0] drive_busy,
  input  logic               done_strobe,
  input  logic [ERR_W-1:0]   done_err,
  output logic               irq,
  output logic               cmd_start,
  output logic [2:0]         cmd_func,
  output logic [DRV_W-1:0]   cmd_drive
);
  localparam int EXT_PAD = WORD_W - EXT_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [2:0] ridx;
  logic       hi_lane, wr_acc, rd_acc;
  logic       hit_csr, hit_ba, hit_da, hit_mp, hit_ext;

  assign ridx    = bus_addr[3:1];
  assign hi_lane = bus_addr[0];
  assign wr_acc  = bus_sel && bus_wr;
  assign rd_acc  = bus_sel && !bus_wr;
  assign hit_csr = (ridx == RI_CSR);
  assign hit_ba  = (ridx == RI_BA);
  assign hit_da  = (ridx == RI_DA);
  assign hit_mp  = (ridx == RI_MP);
  assign hit_ext = (ridx == RI_EXT);

  logic [2:0]         func_q;
  logic               ie_q, done_q, irq_q, start_q;
  logic [DRV_W-1:0]   drv_q;
  logic [ERR_W-1:0]   err_q;
  logic [WORD_W-1:0]  ba_q, da_q, mp_head;
  logic [EXT_W-1:0]   ext_q;
  logic [WORD_W-1:0]  csr_img, csr_wd, ba_wd, da_wd, mp_wd;

  assign csr_img = {|err_q, err_q, drv_q, done_q, ie_q,
                    ext_q[MX_W-1:0], func_q, ~drive_busy[drv_q]};

  assign csr_wd = lane_merge(csr_img, bus_wdata, bus_byte, hi_lane);
  assign ba_wd  = lane_merge(ba_q,    bus_wdata, bus_byte, hi_lane);
  assign da_wd  = lane_merge(da_q,    bus_wdata, bus_byte, hi_lane);
  assign mp_wd  = lane_merge(mp_head, bus_wdata, bus_byte, hi_lane);

  logic unused_bits;
  assign unused_bits = ^{csr_wd[WORD_W-1:C_ERR_LO], csr_wd[C_RDY], ba_wd[0]};

  dkr_csr_ctl u_csr (
    .clk         (clk),
    .rst_n       (rst_s),
    .wr_en       (wr_acc && hit_csr),
    .wr_func     (csr_wd[C_FN_LO +: 3]),
    .wr_ie       (csr_wd[C_IE]),
    .wr_done     (csr_wd[C_DONE]),
    .wr_drv      (csr_wd[C_DRV_LO +: DRV_W]),
    .done_strobe (done_strobe),
    .done_err    (done_err),
    .func_q      (func_q),
    .ie_q        (ie_q),
    .done_q      (done_q),
    .drv_q       (drv_q),
    .err_q       (err_q),
    .irq_q       (irq_q),
    .start_q     (start_q)
  );

  dkr_addr_regs #(.EXT_W(EXT_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_s),
    .ba_we     (wr_acc && hit_ba),
    .ba_wdata  (ba_wd[WORD_W-1:1]),
    .da_we     (wr_acc && hit_da),
    .da_wdata  (da_wd),
    .ext_we    (wr_acc && hit_ext && !(bus_byte && hi_lane)),
    .ext_en    (mode_ext),
    .ext_wdata (bus_wdata[EXT_W-1:0]),
    .mx_we     (wr_acc && hit_csr),
    .mx_wdata  (csr_wd[C_MX_LO +: MX_W]),
    .ba_q      (ba_q),
    .da_q      (da_q),
    .ext_q     (ext_q)
  );

  dkr_mp_queue #(.DEPTH(MPQ_DEPTH), .W(WORD_W)) u_mpq (
    .clk       (clk),
    .rst_n     (rst_s),
    .load      (wr_acc && hit_mp),
    .load_data (mp_wd),
    .pop       (rd_acc && hit_mp),
    .head      (mp_head)
  );

  always_comb begin
    bus_rdata = '0;
    bus_ack   = 1'b0;
    if (bus_sel) begin
      unique case (ridx)
        RI_CSR: begin bus_rdata = csr_img; bus_ack = 1'b1; end
        RI_BA:  begin bus_rdata = ba_q;    bus_ack = 1'b1; end
        RI_DA:  begin bus_rdata = da_q;    bus_ack = 1'b1; end
        RI_MP:  begin bus_rdata = mp_head; bus_ack = 1'b1; end
        RI_EXT: if (mode_ext) begin
                  bus_rdata = {{EXT_PAD{1'b0}}, ext_q};
                  bus_ack   = 1'b1;
                end
        default: ;
      endcase
    end
  end

  assign irq       = irq_q;
  assign cmd_start = start_q;
  assign cmd_func  = func_q;
  assign cmd_drive = drv_q;

  // R10: a full-word control write with done clear launches a command
  p_start_on_go_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_sel && bus_wr && !bus_byte && bus_addr == '0 && !bus_wdata[C_DONE])
      |=> (cmd_start && !irq));
  // R11: reported errors show up in the summary bit
  p_err_summary_r11: assert property (@(posedge clk) disable iff (!rst_s)
    (done_strobe && |done_err) |=> csr_img[C_SUM]);
endmodule

// File: tb/test_cart_disk_regs.sv
module test_cart_disk_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_ext;
  logic        bus_sel, bus_wr, bus_byte;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ack;
  logic [3:0]  drive_busy;
  logic        done_strobe;
  logic [4:0]  done_err;
  logic        irq, cmd_start;
  logic [2:0]  cmd_func;
  logic [1:0]  cmd_drive;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_disk_regs i_cart_disk_regs (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .drive_busy(drive_busy),
    .done_strobe(done_strobe), .done_err(done_err), .irq(irq),
    .cmd_start(cmd_start), .cmd_func(cmd_func), .cmd_drive(cmd_drive)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // reference state
  logic [2:0]  m_func;
  logic        m_ie, m_done, m_irq, m_start;
  logic [1:0]  m_drv;
  logic [4:0]  m_err;
  logic [15:0] m_ba, m_da;
  logic [5:0]  m_ext;
  logic [15:0] m_q [3];

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_csr();
    return {|m_err, m_err, m_drv, m_done, m_ie, m_ext[1:0], m_func, ~drive_busy[m_drv]};
  endfunction

  function automatic logic [15:0] mrg(input logic [15:0] cur, input logic [15:0] wd,
                                      input logic byt, input logic hi);
    if (!byt) return wd;
    if (hi)   return {wd[7:0], cur[7:0]};
    return {cur[15:8], wd[7:0]};
  endfunction

  function automatic logic [15:0] exp_read(input logic [2:0] idx);
    case (idx)
      3'd0: return exp_csr();
      3'd1: return m_ba;
      3'd2: return m_da;
      3'd3: return m_q[0];
      3'd4: return {10'd0, m_ext};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] idx);
    case (idx)
      3'd0: return "R5 csr read";
      3'd1: return "R7 bus addr read";
      3'd2: return "R2 disk addr read";
      3'd3: return "R8 queue read";
      3'd4: return "R4 ext read";
      default: return "R2 unmapped";
    endcase
  endfunction

  task automatic model_reset();
    m_func = 0; m_ie = 0; m_done = 1; m_irq = 0; m_start = 0;
    m_drv = 0; m_err = 0; m_ba = 0; m_da = 0; m_ext = 0;
    for (int i = 0; i < 3; i++) m_q[i] = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    logic [2:0] idx;
    logic exp_ack;
    idx = a[3:1];
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_byte = 0; bus_addr = a; bus_wdata = 16'h0;
    #1;
    exp_ack = (idx <= 3) || (idx == 4 && mode_ext);
    chk({req, " ack"}, {15'd0, bus_ack}, {15'd0, exp_ack});
    if (exp_ack) chk(req, bus_rdata, exp_read(idx));
    @(posedge clk); #1;
    bus_sel = 0;
    if (idx == 3) begin m_q[0] = m_q[1]; m_q[1] = m_q[2]; end
    m_start = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic byt);
    logic [2:0] idx;
    logic hi;
    logic [15:0] mg;
    logic od, oi;
    idx = a[3:1]; hi = a[0];
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_byte = byt; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_byte = 0;
    m_start = 0;
    case (idx)
      3'd0: begin
        mg = mrg(exp_csr(), d, byt, hi);
        od = m_done; oi = m_ie;
        m_func = mg[3:1]; m_ext[1:0] = mg[5:4]; m_ie = mg[6];
        m_done = mg[7]; m_drv = mg[9:8];
        if (mg[7]) begin
          if (!mg[6]) m_irq = 0;
          else if (od && !oi) m_irq = 1;
        end else begin
          m_irq = 0; m_err = 0; m_start = 1;
        end
      end
      3'd1: m_ba = mrg(m_ba, d, byt, hi) & 16'hFFFE;
      3'd2: m_da = mrg(m_da, d, byt, hi);
      3'd3: begin
        mg = mrg(m_q[0], d, byt, hi);
        for (int i = 0; i < 3; i++) m_q[i] = mg;
      end
      3'd4: if (mode_ext && !(byt && hi)) m_ext = d[5:0];
      default: ;
    endcase
    chk("R10 start pulse", {15'd0, cmd_start}, {15'd0, m_start});
    chk("R9 irq after write", {15'd0, irq}, {15'd0, m_irq});
    if (m_start) begin
      chk("R10 cmd_func", {13'd0, cmd_func}, {13'd0, m_func});
      chk("R10 cmd_drive", {14'd0, cmd_drive}, {14'd0, m_drv});
    end
  endtask

  task automatic complete(input logic [4:0] e);
    @(negedge clk);
    done_strobe = 1; done_err = e;
    @(posedge clk); #1;
    done_strobe = 0; done_err = 0;
    m_start = 0;
    m_done = 1; m_err = m_err | e;
    if (m_ie) m_irq = 1;
    chk("R11 irq after completion", {15'd0, irq}, {15'd0, m_irq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int sd;
    logic [15:0] d;
    logic [3:0] a;
    int op;
    sd = $urandom(32'h5EED_0042);
    rst_n = 0; mode_ext = 1; bus_sel = 0; bus_wr = 0; bus_byte = 0;
    bus_addr = 0; bus_wdata = 0; drive_busy = 0; done_strobe = 0; done_err = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);

    // R1 reset state
    #1;
    chk("R1 irq at reset", {15'd0, irq}, 16'd0);
    chk("R1 start at reset", {15'd0, cmd_start}, 16'd0);
    rd(4'd0, "R1 csr reset value");
    chk("R1 csr literal", exp_csr(), 16'h0081);
    rd(4'd2, "R1 bus addr reset");
    rd(4'd4, "R1 disk addr reset");
    rd(4'd6, "R1 queue reset");
    rd(4'd8, "R1 ext reset");

    // R5 drive ready follows selected drive
    drive_busy = 4'b0001;
    rd(4'd0, "R5 busy drive 0 ready low");
    drive_busy = 4'b0000;

    // R10 start a read on drive 1
    wr(4'd0, 16'h010C, 1'b0);
    rd(4'd0, "R10 csr after start");
    chk("R10 pulse ended", {15'd0, cmd_start}, 16'd0);

    // R11 completion with incomplete flag, IE off
    complete(5'b00001);
    rd(4'd0, "R11 csr with error summary");

    // R3 done=1 write cannot touch error bits
    wr(4'd0, 16'hFC80, 1'b0);
    rd(4'd0, "R3 errors kept on done write");

    // R9 IE rising while done set raises irq, IE low drops it
    wr(4'd0, 16'h00C0, 1'b0);
    chk("R9 irq raised", {15'd0, irq}, 16'd1);
    wr(4'd0, 16'h0080, 1'b0);
    chk("R9 irq dropped", {15'd0, irq}, 16'd0);

    // R11 start with IE then completion interrupts; R10 start clears irq and errors
    wr(4'd0, 16'h0046, 1'b0);
    rd(4'd0, "R10 errors cleared by start");
    complete(5'b10000);
    chk("R11 irq with IE", {15'd0, irq}, 16'd1);
    wr(4'd0, 16'h0040, 1'b0);
    chk("R10 start drops irq", {15'd0, irq}, 16'd0);
    complete(5'b00000);

    // R6 byte lanes
    wr(4'd1, 16'h0083, 1'b1);
    rd(4'd0, "R6 csr high byte write");
    wr(4'd2, 16'h1235, 1'b0);
    rd(4'd2, "R7 bus addr bit0 zero");
    wr(4'd3, 16'h00AB, 1'b1);
    rd(4'd2, "R6 bus addr high byte");
    wr(4'd2, 16'h00CD, 1'b1);
    rd(4'd2, "R6 bus addr low byte");
    wr(4'd5, 16'h0077, 1'b1);
    rd(4'd4, "R6 disk addr high byte");

    // R4 mirror both ways, R7 ext width
    wr(4'd8, 16'hFFFF, 1'b0);
    rd(4'd8, "R7 ext 6 bits");
    rd(4'd0, "R4 csr shows ext bits");
    wr(4'd0, 16'h0090, 1'b0);
    rd(4'd8, "R4 ext follows csr");
    wr(4'd9, 16'h0000, 1'b1);
    rd(4'd8, "R6 odd ext byte ignored");

    // R2 absent extension and unmapped offsets
    mode_ext = 0;
    rd(4'd8, "R2 ext absent");
    wr(4'd8, 16'h0000, 1'b0);
    mode_ext = 1;
    rd(4'd8, "R2 ext unchanged by absent write");
    rd(4'd10, "R2 offset 10");
    rd(4'd14, "R2 offset 14");

    // R8 queue broadcast load and reads
    wr(4'd6, 16'hBEEF, 1'b0);
    rd(4'd6, "R8 queue entry 0");
    rd(4'd6, "R8 queue entry 1");
    rd(4'd6, "R8 queue entry 2");
    wr(4'd7, 16'h0012, 1'b1);
    rd(4'd6, "R8 queue byte merge");

    // random phase
    for (int k = 0; k < 600; k++) begin
      mode_ext   = ($urandom % 4) != 0;
      drive_busy = $urandom;
      op = $urandom % 8;
      a  = $urandom;
      d  = $urandom;
      if (op < 3) rd(a, tag_of(a[3:1]));
      else if (op < 6) wr(a, d, $urandom % 2);
      else if (op == 6) wr(4'd0, d & 16'hFF7F, 1'b0);
      else complete($urandom);
      if (k % 5 == 0) rd(4'd0, "R5 csr random");
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule